// File: doc/BRIEF.md
# Circular Last Branch Record Stack

This block keeps a rolling history of the most recent taken control transfers of a processor core. Every accepted event carries a 32-bit source address, a 32-bit destination address and a kind: branch, interrupt, exception or debug exception. The block keeps eight records in a ring. A 3-bit top-of-stack pointer names the slot that holds the newest record. When a new record arrives, the pointer steps forward by one modulo 8 and the record is stored at the new position. Each record is packed into one 64-bit word: the source is in the low half and the destination is in the high half.

Recording is controlled by a small state machine with three states:

- `ST_OFF` means recording is disabled.
- `ST_REC` means recording is active.
- `ST_FROZEN` means recording was halted by a debug exception.

The transitions are:

- `ST_OFF -> ST_REC` when the enable input is seen high.
- `ST_REC -> ST_OFF` when the enable input falls.
- `ST_REC -> ST_FROZEN` when a debug exception arrives with enable high.
- `ST_FROZEN -> ST_OFF` when the enable input falls.

A debug exception is never stored and does not disturb the stored history. This lets a debug handler inspect the path that led to the trap. To resume recording, software drops the enable for at least one cycle and raises it again.

Software reads the block through a 4-bit address with registered data. Addresses 0 to 7 select the records. Address 8 returns the pointer. Addresses 9 to 15 return zero.

Top module: `lbr_stack`

## Requirements
- R1: After reset the pointer is 7, all eight records read as zero, read data is zero, and the machine is in `ST_OFF`.
- R2: A stored record holds the source address in bits 31..0 and the destination address in bits 63..32. Record n is read at address n (0 to 7).
- R3: Each accepted event first advances the pointer by one modulo 8 and then writes the record at the new pointer value. The first event after reset therefore lands in record 0.
- R4: While in `ST_REC` with enable high, events of kind 0 (branch), 1 (interrupt) and 2 (exception) are all recorded.
- R5: A kind 3 event (debug exception) in `ST_REC` is not recorded. It moves the machine to `ST_FROZEN` and leaves the pointer and all records unchanged.
- R6: In `ST_FROZEN`, events are ignored even while enable stays high. Recording resumes only after enable has been low for at least one cycle and is raised again.
- R7: Events presented while the machine is in `ST_OFF` are ignored. This includes the cycle in which enable is first seen high.
- R8: Read data appears one cycle after the address is presented. Address 8 returns the pointer in bits 2..0 with all other bits zero. Addresses 9 to 15 return zero.
- R9: If an event writes a record in the same cycle that the record is addressed for reading, the read returns the value the record held before the write.
- R10: The ninth accepted event after reset wraps the pointer to 0 and overwrites record 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Recording enable (level) |
| evt_valid | input | 1 | Control-transfer event present this cycle |
| evt_kind | input | 2 | 0 branch, 1 interrupt, 2 exception, 3 debug exception |
| evt_from | input | 32 | Source address of the transfer |
| evt_to | input | 32 | Destination address of the transfer |
| rd_addr | input | 4 | Read address: 0-7 records, 8 pointer, 9-15 zero |
| rd_data | output | 64 | Registered read data |
| tos | output | 3 | Top-of-stack pointer, newest record |

## Verification
A record write and a software read of that same record can fall in the same cycle. The bench provokes this by presenting an event together with a read address equal to the slot the pointer is about to advance to. The scoreboard expects the pre-write contents on that read and the new pair on the read that follows. A debug exception arriving while enable is held high is also exercised, followed by further events in the same state, to show that neither the pointer nor the history moves.

// File: rtl/lbr_pkg.sv
`timescale 1ns/1ps
package lbr_pkg;

    typedef enum logic [1:0] {
        EV_BRANCH = 2'd0,
        EV_INTR   = 2'd1,
        EV_EXC    = 2'd2,
        EV_DEBUG  = 2'd3
    } ev_kind_t;

    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_REC    = 2'd1,
        ST_FROZEN = 2'd2
    } rec_state_t;

endpackage

// File: rtl/lbr_ctrl.sv
`timescale 1ns/1ps
module lbr_ctrl
    import lbr_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             evt_valid,
    input  logic [1:0]       evt_kind,
    output logic [PTR_W-1:0] tos,
    output logic             wr_en,
    output logic [PTR_W-1:0] wr_ptr,
    output rec_state_t       state
);

    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    rec_state_t state_nxt;
    ev_kind_t   kind;
    logic       is_debug;

    assign kind     = ev_kind_t'(evt_kind);
    assign is_debug = (kind == EV_DEBUG);

    // next-state decision
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_OFF: begin
                if (enable) state_nxt = ST_REC;
            end
            ST_REC: begin
                if (!enable)                     state_nxt = ST_OFF;
                else if (evt_valid && is_debug)  state_nxt = ST_FROZEN;
            end
            ST_FROZEN: begin
                if (!enable) state_nxt = ST_OFF;
            end
            default: state_nxt = ST_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nxt;
    end

    // outputs of the machine: write strobe and the slot it targets
    always_comb begin
        wr_en  = 1'b0;
        wr_ptr = (tos == LAST) ? '0 : tos + 1'b1;
        unique case (state)
            ST_REC:    wr_en = enable && evt_valid && !is_debug;
            ST_OFF:    wr_en = 1'b0;
            ST_FROZEN: wr_en = 1'b0;
            default:   wr_en = 1'b0;
        endcase
    end

    // pointer register
    always_ff @(posedge clk) begin
        if (!rst_n)     tos <= LAST;
        else if (wr_en) tos <= wr_ptr;
    end

    AST_TOS_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> tos == (($past(tos) == LAST) ? '0 : $past(tos) + 1'b1)); // R3

    AST_TOS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(tos)); // R5

    AST_DBG_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_REC && enable && evt_valid && evt_kind == 2'd3)
        |=> (state == ST_FROZEN && $stable(tos))); // R5

    AST_FROZEN_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FROZEN && enable) |=> state == ST_FROZEN); // R6

    AST_OFF_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF) |=> $stable(tos)); // R7

endmodule

// File: rtl/lbr_store.sv
`timescale 1ns/1ps
module lbr_store #(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 32,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int REC_W = 2 * ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_ptr,
    input  logic [ADDR_W-1:0] src_addr,
    input  logic [ADDR_W-1:0] dst_addr,
    output logic [REC_W-1:0]  rec [DEPTH]
);

    logic [DEPTH-1:0] we_vec;
    logic [REC_W-1:0] packed_rec;

    // destination in the upper half, source in the lower half
    assign packed_rec = {dst_addr, src_addr};

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        assign we_vec[i] = wr_en && (wr_ptr == PTR_W'(i));

        always_ff @(posedge clk) begin
            if (!rst_n)         rec[i] <= '0;
            else if (we_vec[i]) rec[i] <= packed_rec;
        end

        AST_SLOT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
            !we_vec[i] |=> $stable(rec[i])); // R5
    end

    AST_WE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(we_vec)); // R3

endmodule

// File: rtl/lbr_rdport.sv
`timescale 1ns/1ps
module lbr_rdport #(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 32,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int REC_W = 2 * ADDR_W,
    localparam int RA_W  = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [RA_W-1:0]  rd_addr,
    input  logic [REC_W-1:0] rec [DEPTH],
    input  logic [PTR_W-1:0] tos,
    output logic [REC_W-1:0] rd_data
);

    localparam logic [RA_W-1:0] TOS_ADDR = RA_W'(DEPTH);

    logic [REC_W-1:0] sel;

    always_comb begin
        if (rd_addr < TOS_ADDR)       sel = rec[rd_addr[PTR_W-1:0]];
        else if (rd_addr == TOS_ADDR) sel = {{(REC_W-PTR_W){1'b0}}, tos};
        else                          sel = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_data <= '0;
        else        rd_data <= sel;
    end

    AST_RD_UNMAPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr > TOS_ADDR) |=> rd_data == '0); // R8

    AST_RD_TOS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == TOS_ADDR) |=> rd_data[PTR_W-1:0] == $past(tos)); // R8

endmodule

// File: rtl/lbr_stack.sv
`timescale 1ns/1ps
module lbr_stack
    import lbr_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 32,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int REC_W = 2 * ADDR_W,
    localparam int RA_W  = PTR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              evt_valid,
    input  logic [1:0]        evt_kind,
    input  logic [ADDR_W-1:0] evt_from,
    input  logic [ADDR_W-1:0] evt_to,
    input  logic [RA_W-1:0]   rd_addr,
    output logic [REC_W-1:0]  rd_data,
    output logic [PTR_W-1:0]  tos
);

    logic             wr_en;
    logic [PTR_W-1:0] wr_ptr;
    rec_state_t       state;
    logic [REC_W-1:0] rec [DEPTH];

    lbr_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .evt_valid (evt_valid),
        .evt_kind  (evt_kind),
        .tos       (tos),
        .wr_en     (wr_en),
        .wr_ptr    (wr_ptr),
        .state     (state)
    );

    lbr_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_ptr   (wr_ptr),
        .src_addr (evt_from),
        .dst_addr (evt_to),
        .rec      (rec)
    );

    lbr_rdport #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_addr (rd_addr),
        .rec     (rec),
        .tos     (tos),
        .rd_data (rd_data)
    );

    AST_FROZEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FROZEN) |=> $stable(tos)); // R6

endmodule

// File: tb/lbr_stack_test.sv
`timescale 1ns/1ps
module lbr_stack_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        enable;
    logic        evt_valid;
    logic [1:0]  evt_kind;
    logic [31:0] evt_from;
    logic [31:0] evt_to;
    logic [3:0]  rd_addr;
    logic [63:0] rd_data;
    logic [2:0]  tos;

    always #2.5 clk = ~clk;

    lbr_stack uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .evt_valid(evt_valid),
        .evt_kind(evt_kind), .evt_from(evt_from), .evt_to(evt_to),
        .rd_addr(rd_addr), .rd_data(rd_data), .tos(tos)
    );

    int checks = 0;
    int errors = 0;

    // requirement-level model
    logic [63:0] m_ent [8];
    logic [2:0]  m_tos;
    int          m_st;      // 0 off, 1 recording, 2 frozen

    logic [63:0] exp_q [$];
    string       tag_q [$];
    logic        rd_vld = 1'b0;
    string       cur_tag = "R1";
    logic        run = 1'b0;

    task automatic step(input logic v, input logic [1:0] k,
                        input logic [31:0] f, input logic [31:0] t,
                        input logic en, input logic rv,
                        input logic [3:0] a, input string tag);
        logic [63:0] e;
        @(negedge clk);
        evt_valid = v; evt_kind = k; evt_from = f; evt_to = t;
        enable = en; rd_addr = a; rd_vld = rv; cur_tag = tag;
        if (rv) begin
            if (a < 4'd8)       e = m_ent[a[2:0]];
            else if (a == 4'd8) e = {61'b0, m_tos};
            else                e = '0;
            exp_q.push_back(e);
            tag_q.push_back(tag);
        end
        if (m_st == 1 && en && v && k != 2'd3) begin
            m_tos = m_tos + 3'd1;
            m_ent[m_tos] = {t, f};
        end
        case (m_st)
            0: if (en) m_st = 1;
            1: if (!en) m_st = 0; else if (v && k == 2'd3) m_st = 2;
            2: if (!en) m_st = 0;
            default: m_st = 0;
        endcase
    endtask

    task automatic idle(input logic en, input string tag);
        step(1'b0, 2'd0, 32'h0, 32'h0, en, 1'b0, 4'd0, tag);
    endtask

    task automatic rd(input logic [3:0] a, input logic en, input string tag);
        step(1'b0, 2'd0, 32'h0, 32'h0, en, 1'b1, a, tag);
    endtask

    task automatic ev(input logic [1:0] k, input logic [31:0] f,
                      input logic [31:0] t, input logic en, input string tag);
        step(1'b1, k, f, t, en, 1'b0, 4'd0, tag);
    endtask

    // monitor: pointer every cycle, queued read results one cycle after request
    always @(posedge clk) begin
        logic  rvs;
        string tg;
        if (run) begin
            rvs = rd_vld;
            tg  = cur_tag;
            #1;
            checks++;
            if (tos !== m_tos) begin
                errors++;
                $display("FAIL %s pointer got %0d expected %0d", tg, tos, m_tos);
            end
            if (rvs) begin
                logic [63:0] e;
                string       rt;
                e  = exp_q.pop_front();
                rt = tag_q.pop_front();
                checks++;
                if (rd_data !== e) begin
                    errors++;
                    $display("FAIL %s read got %h expected %h", rt, rd_data, e);
                end
            end
        end
    end

    initial begin
        #1000000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) m_ent[i] = '0;
        m_tos = 3'd7;
        m_st  = 0;
        rst_n = 1'b0; enable = 1'b0; evt_valid = 1'b0; evt_kind = 2'd0;
        evt_from = '0; evt_to = '0; rd_addr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        run   = 1'b1;
        // R1 reset contents and pointer
        for (int i = 0; i < 8; i++) rd(4'(i), 1'b0, "R1");
        rd(4'd8, 1'b0, "R1");
        // R7 events with enable low are dropped
        ev(2'd0, 32'h1000_0000, 32'h2000_0000, 1'b0, "R7");
        ev(2'd1, 32'h1000_0004, 32'h2000_0004, 1'b0, "R7");
        rd(4'd0, 1'b0, "R7");
        // R7 event in the cycle enable is first seen high
        ev(2'd0, 32'h1111_1111, 32'h2222_2222, 1'b1, "R7");
        rd(4'd0, 1'b1, "R7");
        // R4 all three recordable kinds; R2 layout; R3 first lands in 0
        ev(2'd0, 32'hA000_0010, 32'hB000_0020, 1'b1, "R4");
        rd(4'd0, 1'b1, "R2");
        ev(2'd1, 32'hA000_0030, 32'hC000_0000, 1'b1, "R4");
        ev(2'd2, 32'hA000_0040, 32'hC000_0100, 1'b1, "R4");
        rd(4'd1, 1'b1, "R4");
        rd(4'd2, 1'b1, "R4");
        rd(4'd8, 1'b1, "R3");
        // R9 write and read of slot 3 in the same cycle
        step(1'b1, 2'd0, 32'h0303_0303, 32'h3030_3030, 1'b1, 1'b1, 4'd3, "R9");
        rd(4'd3, 1'b1, "R9");
        // R10 fill and wrap
        for (int i = 0; i < 5; i++)
            ev(2'(i % 3), 32'h5000_0000 + 32'(i), 32'h6000_0000 + 32'(i), 1'b1, "R10");
        rd(4'd8, 1'b1, "R10");
        rd(4'd0, 1'b1, "R10");
        rd(4'd7, 1'b1, "R10");
        // R8 unmapped addresses
        rd(4'd9, 1'b1, "R8");
        rd(4'd15, 1'b1, "R8");
        rd(4'd12, 1'b1, "R8");
        // R5 debug exception: not stored, freezes
        ev(2'd3, 32'hDEAD_0000, 32'hBEEF_0000, 1'b1, "R5");
        rd(4'd1, 1'b1, "R5");
        rd(4'd8, 1'b1, "R5");
        // R6 frozen with enable still high
        ev(2'd0, 32'h7777_0000, 32'h8888_0000, 1'b1, "R6");
        ev(2'd2, 32'h7777_0004, 32'h8888_0004, 1'b1, "R6");
        rd(4'd1, 1'b1, "R6");
        rd(4'd2, 1'b1, "R6");
        // R6 drop enable one cycle, raise, resume
        idle(1'b0, "R6");
        idle(1'b1, "R6");
        ev(2'd0, 32'h9999_0000, 32'hAAAA_0000, 1'b1, "R6");
        rd(4'd1, 1'b1, "R6");
        rd(4'd8, 1'b1, "R6");
        // R7 disabled again: ignored
        idle(1'b0, "R7");
        ev(2'd1, 32'hCCCC_0000, 32'hDDDD_0000, 1'b0, "R7");
        rd(4'd2, 1'b0, "R7");
        idle(1'b0, "R7");
        idle(1'b0, "R7");
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R8 pending reads got %0d expected 0", exp_q.size());
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule